// File: doc/BRIEF.md
# Single-Segment Memory/Card DMA Channel

This block is the data mover inside an SD host controller. One transfer moves one contiguous region of system memory to or from the card data FIFO. Software sets up a packed mode word, a start address split into two 32-bit halves and a pair of channel-enable bits, then writes a start bit that clears itself. The data engine supplies the block count and block size. The channel multiplies them to get the byte total and issues beats of 1, 2, 4 or 8 bytes until that total is covered.

Memory is reached through a request/grant port with at most one request outstanding. Read data comes back on a separate valid strobe. Toward the card there is a valid/ready push port, used when memory is the source, and a valid/ready pop port, used when the card is the source. When the last beat finishes, the channel raises a one-cycle done pulse. Software aborts a transfer by clearing the enable bit of the running channel and then setting it again.

Top module: `sd_dma_channel`

## Requirements
- R1: Register readback at byte offsets 0x410 (mode), 0x414 (control), 0x418 (channel enable), 0x440 (address bits 31:0) and 0x444 (address bits 63:32). Mode keeps only bits 17:16 (direction), 5:4 (width code) and 0 (increment), and all other mode bits read 0. Channel enable keeps bits 9:8 and resets to both set. Mode and address reset to 0.
- R2: Writing control bit 0 high while idle starts a transfer. Control bit 0 always reads 0, and control bit 2 reads 1 from the start until the done pulse has ended.
- R3: With direction 0, each beat reads memory (mem_we low) and then pushes the unchanged 64-bit read data on tx_data. Beats appear in address order.
- R4: With direction 1, each beat pops one word from rx_data and then writes that word to memory with mem_we high.
- R5: Width code w (0..3) gives beats of 2^w bytes. mem_size equals w, and a transfer of N bytes takes ceil(N / 2^w) beats.
- R6: With the increment bit set, the address advances by 2^w after every beat. With the bit clear, every beat uses the start address.
- R7: The byte total is blk_count × blk_size, latched at start. A total of zero gives a done pulse with no memory request.
- R8: done is high for exactly one cycle, in the cycle after the final beat's completion handshake (FIFO push accepted, or write granted).
- R9: A start is refused if any of these holds: the address is not a multiple of 2^w, the direction field is 2 or 3, or the enable bit of the selected channel is 0. Bit 8 serves direction 0 and bit 9 serves direction 1. A refused start sets control bit 1, which stays set until software writes 1 to control bit 1.
- R10: Clearing the enable bit of the running channel drops any request, returns the channel to idle and suppresses done. Clearing the other channel's bit has no effect on the transfer.
- R11: A pending mem_req keeps its address, size and write flag until mem_gnt. Read data is taken only on mem_rvalid. Request, push, pop and done are never active together.
- R12: A start written while a transfer runs is ignored and sets no error. The running transfer keeps its latched mode, address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| blk_count | input | 16 | Blocks in the transfer, sampled at start |
| blk_size | input | 12 | Bytes per block, sampled at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Push word toward card |
| tx_data | output | 64 | Pushed word |
| tx_ready | input | 1 | Card FIFO accepts push |
| rx_valid | input | 1 | Card FIFO has a word |
| rx_data | input | 64 | Word from card |
| rx_ready | output | 1 | Channel pops the word |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situation to reach from the ports is an abort that lands while a beat is half finished: a read request has been granted but its data has not arrived, or a push is stalled waiting for ready. The bench stalls grants, read returns and FIFO readiness on differing cycle patterns, so a long transfer always has some beat in flight. It then clears one enable bit in the middle of that transfer. It clears the idle channel's bit during a running transfer, together with a second start and a mode rewrite, to show that all three leave the latched transfer untouched.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;
   localparam logic [11:0] OFS_MODE    = 12'h410;
   localparam logic [11:0] OFS_CTRL    = 12'h414;
   localparam logic [11:0] OFS_ENABLE  = 12'h418;
   localparam logic [11:0] OFS_ADDR_LO = 12'h440;
   localparam logic [11:0] OFS_ADDR_HI = 12'h444;
   localparam int          DATA_W      = 64;

   typedef struct packed {
      logic [1:0] dir;
      logic [1:0] width;
      logic       inc;
   } mode_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_PUSH, ST_POP, ST_WR_REQ, ST_DONE
   } seq_state_t;
endpackage

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_we,
   input  logic              busy,
   input  logic              err_set,
   output logic [31:0]       reg_rdata,
   output mode_t             mode,
   output logic [ADDR_W-1:0] base_addr,
   output logic [1:0]        chan_run,
   output logic              start_wr,
   output logic              err
);
   localparam int LO_W = (ADDR_W > 32) ? 32 : ADDR_W;
   localparam int HI_W = (ADDR_W > 32) ? ADDR_W - 32 : 1;

   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
      $error("sd_dma_regs: ADDR_W must lie in 4..64");
   end

   logic              wr_mode, wr_ctrl, wr_en, wr_lo, wr_hi;
   logic [LO_W-1:0]   addr_lo;
   logic [31:0]       hi_rd;

   assign wr_mode  = reg_we && (reg_addr == OFS_MODE);
   assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
   assign wr_en    = reg_we && (reg_addr == OFS_ENABLE);
   assign wr_lo    = reg_we && (reg_addr == OFS_ADDR_LO);
   assign wr_hi    = reg_we && (reg_addr == OFS_ADDR_HI);
   assign start_wr = wr_ctrl && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= '0;
         chan_run <= 2'b11;
         addr_lo  <= '0;
         err      <= 1'b0;
      end else begin
         if (wr_mode)
            mode <= '{dir: reg_wdata[17:16], width: reg_wdata[5:4], inc: reg_wdata[0]};
         if (wr_en)
            chan_run <= reg_wdata[9:8];
         if (wr_lo)
            addr_lo <= reg_wdata[LO_W-1:0];
         if (err_set)
            err <= 1'b1;
         else if (wr_ctrl && reg_wdata[1])
            err <= 1'b0;
      end
   end

   if (ADDR_W > 32) begin : g_wide_addr
      logic [HI_W-1:0] addr_hi;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_hi <= '0;
         else if (wr_hi)
            addr_hi <= reg_wdata[HI_W-1:0];
      end
      assign base_addr = {addr_hi, addr_lo};
      assign hi_rd     = 32'(addr_hi);
   end else begin : g_narrow_addr
      logic unused_hi;
      assign unused_hi = wr_hi;
      assign base_addr = addr_lo;
      assign hi_rd     = '0;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_MODE:    reg_rdata = {14'b0, mode.dir, 10'b0, mode.width, 3'b0, mode.inc};
         OFS_CTRL:    reg_rdata = {29'b0, busy, err, 1'b0};
         OFS_ENABLE:  reg_rdata = {22'b0, chan_run, 8'b0};
         OFS_ADDR_LO: reg_rdata = 32'(addr_lo);
         OFS_ADDR_HI: reg_rdata = hi_rd;
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sd_dma_len.sv
module sd_dma_len #(
   parameter int TOT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOT_W-1:0] total,
   input  logic             step,
   input  logic [1:0]       width,
   output logic             last
);
   if (TOT_W < 4) begin : g_bad_tot_w
      $error("sd_dma_len: TOT_W must be at least 4");
   end

   logic [TOT_W-1:0] remain;
   logic [TOT_W-1:0] beat_bytes;

   assign beat_bytes = TOT_W'(1) << width;
   assign last       = (remain <= beat_bytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= total;
      else if (step)
         remain <= last ? '0 : remain - beat_bytes;
   end
endmodule

// File: rtl/sd_dma_seq.sv
module sd_dma_seq
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  mode_t             mode,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [1:0]        chan_run,
   input  logic              total_zero,
   input  logic              last,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              load,
   output logic              step,
   output logic [1:0]        width_q,
   output logic              err_set,
   output logic              busy,
   output logic              abort,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_ready
);
   seq_state_t        state, nxt;
   logic              dir_q, inc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] align_mask;
   logic              idle, legal, accept;

   assign idle       = (state == ST_IDLE);
   assign align_mask = (ADDR_W'(1) << mode.width) - ADDR_W'(1);
   assign legal      = !mode.dir[1] && chan_run[mode.dir[0]] &&
                       ((base_addr & align_mask) == '0);
   assign accept     = start_wr && idle && legal;
   assign err_set    = start_wr && idle && !legal;
   assign load       = accept;
   assign abort      = !idle && (state != ST_DONE) && !chan_run[dir_q];
   assign step       = !abort && (((state == ST_PUSH) && tx_ready) ||
                                  ((state == ST_WR_REQ) && mem_gnt));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (accept) nxt = total_zero ? ST_DONE :
                                       (mode.dir[0] ? ST_POP : ST_RD_REQ);
         ST_RD_REQ:  if (mem_gnt)    nxt = ST_RD_WAIT;
         ST_RD_WAIT: if (mem_rvalid) nxt = ST_PUSH;
         ST_PUSH:    if (tx_ready)   nxt = last ? ST_DONE : ST_RD_REQ;
         ST_POP:     if (rx_valid)   nxt = ST_WR_REQ;
         ST_WR_REQ:  if (mem_gnt)    nxt = last ? ST_DONE : ST_POP;
         ST_DONE:    nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
      if (abort) nxt = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dir_q   <= 1'b0;
         inc_q   <= 1'b0;
         width_q <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            dir_q   <= mode.dir[0];
            inc_q   <= mode.inc;
            width_q <= mode.width;
            addr_q  <= base_addr;
         end
         if (step && inc_q)
            addr_q <= addr_q + (ADDR_W'(1) << width_q);
         if ((state == ST_RD_WAIT) && mem_rvalid)
            data_q <= mem_rdata;
         else if ((state == ST_POP) && rx_valid)
            data_q <= rx_data;
      end
   end

   assign busy      = !idle;
   assign done      = (state == ST_DONE);
   assign mem_req   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign mem_we    = (state == ST_WR_REQ);
   assign mem_addr  = addr_q;
   assign mem_size  = width_q;
   assign mem_wdata = data_q;
   assign tx_valid  = (state == ST_PUSH);
   assign tx_data   = data_q;
   assign rx_ready  = (state == ST_POP);
endmodule

// File: rtl/sd_dma_channel.sv
module sd_dma_channel
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int BCNT_W = 16,
   parameter int BSZ_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_we,
   output logic [31:0]       reg_rdata,
   input  logic [BCNT_W-1:0] blk_count,
   input  logic [BSZ_W-1:0]  blk_size,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              done
);
   localparam int TOT_W = BCNT_W + BSZ_W;

   if (BCNT_W < 1 || BSZ_W < 4) begin : g_bad_len_w
      $error("sd_dma_channel: BCNT_W must be >= 1 and BSZ_W >= 4");
   end

   mode_t             mode;
   logic [ADDR_W-1:0] base_addr;
   logic [1:0]        chan_run;
   logic              start_wr, err, err_set, busy, abort;
   logic              load, step, last;
   logic [1:0]        width_q;
   logic [TOT_W-1:0]  total;

   assign total = TOT_W'(blk_count) * TOT_W'(blk_size);

   sd_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .busy(busy), .err_set(err_set), .reg_rdata(reg_rdata),
      .mode(mode), .base_addr(base_addr), .chan_run(chan_run),
      .start_wr(start_wr), .err(err)
   );

   sd_dma_len #(.TOT_W(TOT_W)) u_len (
      .clk(clk), .rst_n(rst_n), .load(load), .total(total), .step(step),
      .width(load ? mode.width : width_q), .last(last)
   );

   sd_dma_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .mode(mode),
      .base_addr(base_addr), .chan_run(chan_run), .total_zero(total == '0),
      .last(last), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .tx_ready(tx_ready), .rx_valid(rx_valid),
      .rx_data(rx_data), .load(load), .step(step), .width_q(width_q),
      .err_set(err_set), .busy(busy), .abort(abort), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .rx_ready(rx_ready)
   );
endmodule

// File: rtl/sd_dma_chk.sv
module sd_dma_chk
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [11:0]       reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              reg_we,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_size,
   input logic              mem_gnt,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_ready,
   input logic              rx_ready,
   input logic              done,
   input logic              busy,
   input logic              abort,
   input logic              err
);
   logic err_clr;
   assign err_clr = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[1];

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !abort) |=> (mem_req && $stable(mem_addr) &&
                                          $stable(mem_size) && $stable(mem_we))); // R11
   AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, tx_valid, rx_ready, done})); // R11
   AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data))); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr & ((ADDR_W'(1) << mem_size) - ADDR_W'(1))) == '0)); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_clr) |=> err); // R9
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !done && !mem_req)); // R10
endmodule

bind sd_dma_channel sd_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_we(reg_we), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_size(mem_size), .mem_gnt(mem_gnt), .tx_valid(tx_valid),
   .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready), .done(done),
   .busy(busy), .abort(abort), .err(err)
);

// File: tb/test_sd_dma_channel.sv
`timescale 1ns/1ps
module test_sd_dma_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [15:0] blk_count = '0;
   logic [11:0] blk_size = '0;
   logic        mem_req, mem_we;
   logic [63:0] mem_addr, mem_wdata, tx_data;
   logic [1:0]  mem_size;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0, rx_data = '0;
   logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, done;

   always #2 clk = ~clk;

   sd_dma_channel i_sd_dma_channel (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .blk_count(blk_count),
      .blk_size(blk_size), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .done(done)
   );

   int total = 0, fails = 0;
   int cyc = 0, n_mem = 0, n_tx = 0, n_rx = 0, n_done = 0;
   logic [63:0] alog [256];
   logic [1:0]  slog [256];
   logic        welog [256];
   logic [63:0] wlog [256];
   logic [63:0] txlog [256];
   logic        rd_pend = 1'b0;
   logic [63:0] rd_addr = '0;
   localparam logic [63:0] BASE = 64'h0000_0001_0000_0040;

   function automatic logic [63:0] rd_pat(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_5A5A, a[31:0]};
   endfunction
   function automatic logic [63:0] rx_pat(input int k);
      return {32'hC0DE_0000 + 32'(k), 32'h0000_1000 + 32'(k)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory and card FIFO models, driven away from the active edge
   always @(negedge clk) begin
      cyc++;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
         mem_rvalid = 1'b1; mem_rdata = rd_pat(rd_addr); rd_pend = 1'b0;
      end
      if (mem_gnt) begin
         mem_gnt = 1'b0;
         if (!welog[(n_mem - 1) & 255]) begin rd_pend = 1'b1; rd_addr = alog[(n_mem - 1) & 255]; end
      end else if (mem_req && (cyc % 3 != 0)) begin
         mem_gnt = 1'b1;
         alog[n_mem & 255] = mem_addr; slog[n_mem & 255] = mem_size;
         welog[n_mem & 255] = mem_we;  wlog[n_mem & 255] = mem_wdata;
         n_mem++;
      end
      if (tx_ready) tx_ready = 1'b0;
      else if (tx_valid && (cyc % 2 == 1)) begin
         tx_ready = 1'b1; txlog[n_tx & 255] = tx_data; n_tx++;
      end
      if (rx_valid) rx_valid = 1'b0;
      else if (rx_ready && (cyc % 4 != 2)) begin
         rx_valid = 1'b1; rx_data = rx_pat(n_rx); n_rx++;
      end
      if (done) n_done++;
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask
   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask
   task automatic clear_logs();
      @(negedge clk); #1 n_mem = 0; n_tx = 0; n_rx = 0; n_done = 0;
   endtask
   task automatic setup(input logic [63:0] a, input int dir, input int w, input int inc);
      wr(12'h440, a[31:0]); wr(12'h444, a[63:32]);
      wr(12'h410, (32'(dir) << 16) | (32'(w) << 4) | 32'(inc));
   endtask
   task automatic wait_done(input int lim);
      for (int i = 0; i < lim; i++) begin
         @(negedge clk); #1;
         if (n_done != 0) break;
      end
   endtask

   task automatic run_xfer(input int dir, input int w, input int inc);
      logic [63:0] base, ea;
      logic [31:0] r;
      int beats;
      base  = BASE + ((w == 0) ? 64'd1 : 64'd0);
      beats = (12 + (1 << w) - 1) >> w;
      blk_count = 16'd3; blk_size = 12'd4;
      setup(base, dir, w, inc);
      clear_logs();
      wr(12'h414, 32'h1);
      wait_done(2000);
      repeat (3) @(negedge clk);
      #1;
      chk(n_done == 1, "R8 done count", 64'(n_done), 64'd1);
      chk(n_mem == beats, "R5 beat count", 64'(n_mem), 64'(beats));
      for (int k = 0; k < beats && k < n_mem; k++) begin
         ea = inc ? base + (64'(k) << w) : base;
         chk(alog[k] == ea, "R6 beat address", alog[k], ea);
         chk(slog[k] == 2'(w), "R5 size code", 64'(slog[k]), 64'(w));
         chk(welog[k] == dir[0], dir ? "R4 write flag" : "R3 read flag",
             64'(welog[k]), 64'(dir));
         if (dir == 0) chk(k < n_tx && txlog[k] == rd_pat(ea), "R3 pushed data", txlog[k], rd_pat(ea));
         else          chk(wlog[k] == rx_pat(k), "R4 written data", wlog[k], rx_pat(k));
      end
      if (dir == 0) chk(n_tx == beats, "R3 push count", 64'(n_tx), 64'(beats));
      else          chk(n_rx == beats, "R4 pop count", 64'(n_rx), 64'(beats));
      rd(12'h414, r);
      chk(r == 32'h0, "R2 control idle after done", 64'(r), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state and readback
      rd(12'h410, r); chk(r == 0, "R1 mode reset", 64'(r), 0);
      rd(12'h414, r); chk(r == 0, "R2 control reset", 64'(r), 0);
      rd(12'h418, r); chk(r == 32'h300, "R1 enable reset", 64'(r), 64'h300);
      rd(12'h440, r); chk(r == 0, "R1 address low reset", 64'(r), 0);
      chk(!mem_req && !done && !tx_valid && !rx_ready, "R11 outputs quiet at reset",
          64'({mem_req, done, tx_valid, rx_ready}), 0);
      wr(12'h410, 32'hFFFF_FFFF);
      rd(12'h410, r); chk(r == 32'h0003_0031, "R1 mode field mask", 64'(r), 64'h30031);
      wr(12'h444, 32'hDEAD_BEEF);
      rd(12'h444, r); chk(r == 32'hDEAD_BEEF, "R1 address high", 64'(r), 64'hDEADBEEF);

      // refused starts
      blk_count = 16'd3; blk_size = 12'd4;
      wr(12'h418, 32'h200);
      setup(BASE, 0, 2, 1); clear_logs(); wr(12'h414, 32'h1);
      repeat (4) @(negedge clk);
      rd(12'h414, r); chk(r == 32'h2, "R9 start on held channel 0", 64'(r), 64'h2);
      chk(n_mem == 0, "R9 no request when refused", 64'(n_mem), 0);
      wr(12'h414, 32'h2);
      rd(12'h414, r); chk(r == 0, "R9 error cleared by write", 64'(r), 0);
      wr(12'h418, 32'h300);
      setup(BASE + 64'd4, 0, 3, 1); wr(12'h414, 32'h1);
      rd(12'h414, r); chk(r == 32'h2, "R9 misaligned 64-bit start", 64'(r), 64'h2);
      wr(12'h414, 32'h2);
      setup(BASE + 64'd1, 1, 1, 1); wr(12'h414, 32'h1);
      rd(12'h414, r); chk(r == 32'h2, "R9 misaligned 16-bit start", 64'(r), 64'h2);
      wr(12'h414, 32'h2);
      setup(BASE, 2, 0, 1); wr(12'h414, 32'h1);
      rd(12'h414, r); chk(r == 32'h2, "R9 reserved direction", 64'(r), 64'h2);
      wr(12'h414, 32'h2);

      // zero length
      blk_count = 16'd0;
      setup(BASE, 0, 0, 1); clear_logs(); wr(12'h414, 32'h1);
      repeat (4) @(negedge clk); #1;
      chk(n_done == 1, "R7 zero length done", 64'(n_done), 1);
      chk(n_mem == 0, "R7 zero length no request", 64'(n_mem), 0);

      // second start, mode rewrite and other channel's enable during a run
      blk_count = 16'd10; blk_size = 12'd20;
      setup(BASE, 0, 0, 1); clear_logs(); wr(12'h414, 32'h1);
      repeat (10) @(negedge clk);
      rd(12'h414, r); chk(r == 32'h4, "R2 busy while running", 64'(r), 64'h4);
      wr(12'h410, 32'h0001_0030); wr(12'h414, 32'h1);
      rd(12'h414, r); chk(r == 32'h4, "R12 start while busy sets no error", 64'(r), 64'h4);
      wr(12'h418, 32'h100);
      wait_done(5000);
      repeat (3) @(negedge clk); #1;
      chk(n_done == 1, "R10 other channel bit leaves transfer", 64'(n_done), 1);
      chk(n_mem == 200, "R12 latched length kept", 64'(n_mem), 200);
      chk(alog[199] == BASE + 64'd199, "R12 latched address kept", alog[199], BASE + 64'd199);
      chk(slog[199] == 2'd0 && welog[199] == 1'b0, "R12 latched mode kept",
          64'({slog[199], welog[199]}), 0);
      wr(12'h418, 32'h300);

      // abort of a running memory-to-card transfer
      setup(BASE, 0, 2, 1); clear_logs(); wr(12'h414, 32'h1);
      repeat (30) @(negedge clk);
      wr(12'h418, 32'h200);
      repeat (2) @(negedge clk); #1;
      chk(!mem_req && !tx_valid, "R10 request dropped on abort",
          64'({mem_req, tx_valid}), 0);
      rd(12'h414, r); chk(r == 0, "R10 idle after abort", 64'(r), 0);
      repeat (40) @(negedge clk); #1;
      chk(n_done == 0, "R10 no done after abort", 64'(n_done), 0);
      wr(12'h418, 32'h300);
      // abort of a card-to-memory transfer through bit 9
      setup(BASE, 1, 3, 1); clear_logs(); wr(12'h414, 32'h1);
      repeat (20) @(negedge clk);
      wr(12'h418, 32'h100);
      repeat (40) @(negedge clk); #1;
      chk(n_done == 0 && !mem_req && !rx_ready, "R10 channel 1 abort",
          64'({n_done != 0, mem_req, rx_ready}), 0);
      wr(12'h418, 32'h300);
      repeat (4) @(negedge clk);

      // sweep over direction, width and increment
      for (int d = 0; d < 2; d++)
         for (int w = 0; w < 4; w++)
            for (int inc = 0; inc < 2; inc++)
               run_xfer(d, w, inc);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule